// File: doc/BRIEF.md
# Four-Wide Decode Steering with Microcode Handoff

This block sits between instruction pre-decode and the micro-op queue. Each cycle the fetch side presents a group of up to four instructions, oldest in slot 0, each with a tag and the number of micro-ops it expands into. The slots are not equal. Slot 0 feeds a wide decoder that can expand one instruction into a short run of micro-ops. The other three slots only handle single-micro-op instructions. The block decides how many instructions of the group it takes this cycle and places their micro-ops, in program order, on a four-slot output bus.

An instruction whose expansion is longer than the wide decoder's limit is taken alone. It is handed to a microcode sequencer. The sequencer then streams the micro-ops in beats of up to four, while the fetch side sees backpressure. A later instruction that needs more than one micro-op ends the group: it stays at the head of fetch and becomes slot 0 of a later cycle. A flush cancels a running sequence and consumes nothing in the cycle it is raised. The micro-op payload comes from two stub generators, one for direct decode and one standing in for the microcode ROM.

Top module: `decode_steer`

## Requirements
- R1: While reset is held, and once it is released with no valid input, no output slot is valid, `grp_take` is 0, and `grp_ready` equals `uop_ready`.
- R2: Suppose no sequence is running and there is no flush. When slot 0 holds an instruction of N micro-ops with 1 <= N <= 4, output slots 0..N-1 carry its tag with indices 0..N-1 and `uop_mseq` = 0. Only slot N-1 has `uop_eoi` = 1.
- R3: After slot 0's micro-ops, each following valid instruction with a count of 1 takes the next free output slot, with index 0 and `uop_eoi` = 1. This continues until all four output slots are used.
- R4: `grp_take` equals the number of instructions consumed. The group is cut before the first later instruction whose count is not 1, before the first invalid slot, or once the output slots are full.
- R5: When slot 0's count exceeds 4, only that instruction is taken and no micro-op is output in that cycle. In the following cycles the sequencer outputs micro-ops 0..N-1 in order, four per accepted beat, with `uop_mseq` = 1 and `uop_eoi` = 1 on index N-1.
- R6: `grp_ready` is 0 and `grp_take` is 0 from the cycle after a handoff until the beat that carries the last micro-op is accepted. In the next cycle a new group can be taken.
- R7: While `uop_ready` is 0, `grp_take` is 0 and nothing advances. A sequencer beat keeps its contents until it is accepted.
- R8: A cycle with `flush` = 1 shows no valid output slot, takes nothing, holds `grp_ready` low and ends any running sequence. The next cycle starts from an idle state.
- R9: `uop_word` is the tag XOR the zero-extended index for directly decoded micro-ops. For sequenced micro-ops it is the tag plus three times the index, modulo 256. It is 0 on invalid slots.
- R10: Valid output slots are always contiguous from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Cancel running sequence; consume nothing this cycle |
| grp_valid | input | 4 | Per-slot instruction valid, contiguous from slot 0 |
| grp_tag | input | 4x8 | Per-slot instruction tag |
| grp_cnt | input | 4x5 | Per-slot micro-op count (1..31) |
| grp_ready | output | 1 | A new group can be taken this cycle |
| grp_take | output | 3 | Number of instructions consumed this cycle |
| uop_ready | input | 1 | Consumer accepts the output bus this cycle |
| uop_valid | output | 4 | Per-slot micro-op valid |
| uop_tag | output | 4x8 | Tag of the instruction owning each micro-op |
| uop_idx | output | 4x5 | Micro-op index within its instruction |
| uop_word | output | 4x8 | Stub micro-op payload |
| uop_eoi | output | 4 | Last micro-op of its instruction |
| uop_mseq | output | 4 | Micro-op came from the sequencer |

## Verification
Two functions can meet in one cycle. A flush can coincide with a sequencer beat that is part-way through a long instruction, and it can coincide with the presentation of a fresh group. The bench raises flush after a long instruction has emitted one beat and then stalled for a cycle. It also raises flush on an idle cycle with a group waiting. In both cases it expects an empty bus and no instruction taken. It then expects the unconsumed instructions to decode normally on the next cycle, with the cancelled instruction's remaining micro-ops never appearing. The scoreboard models acceptance and the group cut independently, so any leftover or missing micro-op shows up as an order mismatch.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;
  localparam int DS_SLOTS    = 4;
  localparam int DS_CPLX_MAX = 4;
  localparam int DS_TAG_W    = 8;
  localparam int DS_CNT_W    = 5;

  typedef logic [DS_TAG_W-1:0] tag_t;
  typedef logic [DS_CNT_W-1:0] cnt_t;

  // payload stub for micro-ops produced by the wide/narrow decoders
  function automatic tag_t direct_word(tag_t t, cnt_t i);
    return t ^ tag_t'(i);
  endfunction

  // payload stub standing in for the microcode store: tag + 3*index
  function automatic tag_t rom_word(tag_t t, cnt_t i);
    tag_t e;
    e = tag_t'(i);
    return t + (e << 1) + e;
  endfunction
endpackage

// File: rtl/dsteer_group.sv
module dsteer_group
  import dsteer_pkg::*;
#(
  parameter int SLOTS    = DS_SLOTS,
  parameter int CPLX_MAX = DS_CPLX_MAX,
  parameter int TAG_W    = DS_TAG_W,
  parameter int CNT_W    = DS_CNT_W
) (
  input  logic                        en,
  input  logic [SLOTS-1:0]            grp_valid,
  input  logic [SLOTS-1:0][TAG_W-1:0] grp_tag,
  input  logic [SLOTS-1:0][CNT_W-1:0] grp_cnt,
  output logic [SLOTS-1:0]            d_valid,
  output logic [SLOTS-1:0][TAG_W-1:0] d_tag,
  output logic [SLOTS-1:0][CNT_W-1:0] d_idx,
  output logic [SLOTS-1:0]            d_eoi,
  output logic [$clog2(SLOTS+1)-1:0]  take,
  output logic                        launch
);
  localparam int TAKE_W = $clog2(SLOTS+1);
  localparam int XW     = CNT_W + 1;

  logic [SLOTS-1:0] fits;
  logic [XW-1:0]    n0x;

  always_comb begin
    n0x     = {1'b0, grp_cnt[0]};
    launch  = en && grp_valid[0] && (n0x > XW'(CPLX_MAX));
    fits[0] = en && grp_valid[0] && (n0x <= XW'(CPLX_MAX));
    for (int k = 1; k < SLOTS; k++) begin
      fits[k] = fits[k-1] && grp_valid[k] && (grp_cnt[k] == CNT_W'(1)) &&
                (n0x + XW'(k) <= XW'(SLOTS));
    end
    take = launch ? TAKE_W'(1) : TAKE_W'($countones(fits));
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      d_valid[s] = 1'b0;
      d_tag[s]   = '0;
      d_idx[s]   = '0;
      d_eoi[s]   = 1'b0;
      if (fits[0] && (XW'(s) < n0x)) begin
        d_valid[s] = 1'b1;
        d_tag[s]   = grp_tag[0];
        d_idx[s]   = CNT_W'(s);
        d_eoi[s]   = (XW'(s + 1) == n0x);
      end
      for (int k = 1; k < SLOTS; k++) begin
        if (fits[k] && (n0x + XW'(k - 1) == XW'(s))) begin
          d_valid[s] = 1'b1;
          d_tag[s]   = grp_tag[k];
          d_idx[s]   = '0;
          d_eoi[s]   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsteer_useq.sv
module dsteer_useq
  import dsteer_pkg::*;
#(
  parameter int SLOTS = DS_SLOTS,
  parameter int TAG_W = DS_TAG_W,
  parameter int CNT_W = DS_CNT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        advance,
  input  logic                        launch,
  input  logic [TAG_W-1:0]            l_tag,
  input  logic [CNT_W-1:0]            l_cnt,
  output logic                        busy,
  output logic [TAG_W-1:0]            u_tag,
  output logic [SLOTS-1:0]            u_valid,
  output logic [SLOTS-1:0][CNT_W-1:0] u_idx,
  output logic [SLOTS-1:0]            u_eoi
);
  localparam int XW = CNT_W + 1;

  logic          busy_q;
  logic [TAG_W-1:0] tag_q;
  logic [XW-1:0] total_q;
  logic [XW-1:0] base_q;
  logic          last_beat;

  assign last_beat = (base_q + XW'(SLOTS)) >= total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tag_q   <= '0;
      total_q <= '0;
      base_q  <= '0;
    end else if (flush) begin
      busy_q <= 1'b0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      tag_q   <= l_tag;
      total_q <= {1'b0, l_cnt};
      base_q  <= '0;
    end else if (busy_q && advance) begin
      base_q <= base_q + XW'(SLOTS);
      if (last_beat) busy_q <= 1'b0;
    end
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      u_valid[s] = busy_q && ((base_q + XW'(s)) < total_q);
      u_idx[s]   = CNT_W'(base_q + XW'(s));
      u_eoi[s]   = busy_q && ((base_q + XW'(s + 1)) == total_q);
    end
  end

  assign busy  = busy_q;
  assign u_tag = tag_q;
endmodule

// File: rtl/decode_steer.sv
module decode_steer
  import dsteer_pkg::*;
#(
  parameter int SLOTS    = DS_SLOTS,
  parameter int CPLX_MAX = DS_CPLX_MAX,
  parameter int TAG_W    = DS_TAG_W,
  parameter int CNT_W    = DS_CNT_W,
  localparam int TAKE_W  = $clog2(SLOTS+1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic [SLOTS-1:0]            grp_valid,
  input  logic [SLOTS-1:0][TAG_W-1:0] grp_tag,
  input  logic [SLOTS-1:0][CNT_W-1:0] grp_cnt,
  output logic                        grp_ready,
  output logic [TAKE_W-1:0]           grp_take,
  input  logic                        uop_ready,
  output logic [SLOTS-1:0]            uop_valid,
  output logic [SLOTS-1:0][TAG_W-1:0] uop_tag,
  output logic [SLOTS-1:0][CNT_W-1:0] uop_idx,
  output logic [SLOTS-1:0][TAG_W-1:0] uop_word,
  output logic [SLOTS-1:0]            uop_eoi,
  output logic [SLOTS-1:0]            uop_mseq
);
  // named internal events, observed by the bound checker
  logic seq_busy;
  logic seq_launch;
  logic grp_en;
  logic seq_show;

  logic [SLOTS-1:0]            d_valid, d_eoi, u_valid, u_eoi;
  logic [SLOTS-1:0][TAG_W-1:0] d_tag;
  logic [SLOTS-1:0][CNT_W-1:0] d_idx, u_idx;
  logic [TAG_W-1:0]            u_tag;
  logic [TAKE_W-1:0]           take_raw;
  logic                        launch_raw;

  assign grp_en     = !seq_busy && !flush;
  assign seq_launch = launch_raw && uop_ready;
  assign seq_show   = seq_busy && !flush;

  dsteer_group #(
    .SLOTS(SLOTS), .CPLX_MAX(CPLX_MAX), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_group (
    .en       (grp_en),
    .grp_valid(grp_valid),
    .grp_tag  (grp_tag),
    .grp_cnt  (grp_cnt),
    .d_valid  (d_valid),
    .d_tag    (d_tag),
    .d_idx    (d_idx),
    .d_eoi    (d_eoi),
    .take     (take_raw),
    .launch   (launch_raw)
  );

  dsteer_useq #(
    .SLOTS(SLOTS), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_useq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .advance(uop_ready),
    .launch (seq_launch),
    .l_tag  (grp_tag[0]),
    .l_cnt  (grp_cnt[0]),
    .busy   (seq_busy),
    .u_tag  (u_tag),
    .u_valid(u_valid),
    .u_idx  (u_idx),
    .u_eoi  (u_eoi)
  );

  assign grp_ready = grp_en && uop_ready;
  assign grp_take  = uop_ready ? take_raw : '0;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      if (seq_show) begin
        uop_valid[s] = u_valid[s];
        uop_tag[s]   = u_valid[s] ? u_tag : '0;
        uop_idx[s]   = u_valid[s] ? u_idx[s] : '0;
        uop_eoi[s]   = u_eoi[s];
        uop_mseq[s]  = u_valid[s];
      end else begin
        uop_valid[s] = d_valid[s];
        uop_tag[s]   = d_tag[s];
        uop_idx[s]   = d_idx[s];
        uop_eoi[s]   = d_eoi[s];
        uop_mseq[s]  = 1'b0;
      end
      if (!uop_valid[s])
        uop_word[s] = '0;
      else if (uop_mseq[s])
        uop_word[s] = rom_word(uop_tag[s], uop_idx[s]);
      else
        uop_word[s] = direct_word(uop_tag[s], uop_idx[s]);
    end
  end
endmodule

// File: rtl/decode_steer_chk.sv
module decode_steer_chk #(
  parameter int SLOTS  = 4,
  parameter int CNT_W  = 5,
  parameter int TAKE_W = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        flush,
  input logic                        uop_ready,
  input logic                        grp_ready,
  input logic [TAKE_W-1:0]           grp_take,
  input logic [SLOTS-1:0]            uop_valid,
  input logic [SLOTS-1:0]            uop_eoi,
  input logic [SLOTS-1:0][CNT_W-1:0] uop_idx,
  input logic                        seq_busy,
  input logic                        seq_launch
);
  // R10
  valid_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((uop_valid + SLOTS'(1)) & uop_valid) == '0);

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (uop_valid == '0 && grp_take == '0 && !grp_ready));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !seq_busy);

  // R7
  stall_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uop_ready |-> grp_take == '0);

  // R7
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !uop_ready && !flush) |=> (flush || $stable(uop_idx)));

  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> (!grp_ready && grp_take == '0));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !flush && uop_ready && |(uop_eoi & uop_valid)) |=> !seq_busy);

  // R5
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_launch |-> (uop_valid == '0 && grp_take == TAKE_W'(1)));

  // R5
  handoff_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_launch |=> seq_busy);
endmodule

bind decode_steer decode_steer_chk #(
  .SLOTS(SLOTS), .CNT_W(CNT_W), .TAKE_W(TAKE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .uop_ready (uop_ready),
  .grp_ready (grp_ready),
  .grp_take  (grp_take),
  .uop_valid (uop_valid),
  .uop_eoi   (uop_eoi),
  .uop_idx   (uop_idx),
  .seq_busy  (seq_busy),
  .seq_launch(seq_launch)
);

// File: tb/decode_steer_bench.sv
module decode_steer_bench;
  import dsteer_pkg::*;
  localparam int S  = DS_SLOTS;
  localparam int TW = DS_TAG_W;
  localparam int CW = DS_CNT_W;
  localparam int KW = $clog2(S+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic uop_ready = 1'b0;
  logic [S-1:0]         grp_valid = '0;
  logic [S-1:0][TW-1:0] grp_tag = '0;
  logic [S-1:0][CW-1:0] grp_cnt = '0;
  logic                 grp_ready;
  logic [KW-1:0]        grp_take;
  logic [S-1:0]         uop_valid, uop_eoi, uop_mseq;
  logic [S-1:0][TW-1:0] uop_tag, uop_word;
  logic [S-1:0][CW-1:0] uop_idx;

  always #10 clk = ~clk;

  decode_steer u_decode_steer (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .grp_valid(grp_valid), .grp_tag(grp_tag), .grp_cnt(grp_cnt),
    .grp_ready(grp_ready), .grp_take(grp_take), .uop_ready(uop_ready),
    .uop_valid(uop_valid), .uop_tag(uop_tag), .uop_idx(uop_idx),
    .uop_word(uop_word), .uop_eoi(uop_eoi), .uop_mseq(uop_mseq)
  );

  typedef struct packed {
    logic [TW-1:0] tag;
    logic [CW-1:0] idx;
    logic          eoi;
    logic          mseq;
  } item_t;

  item_t      expq[$];
  logic [TW-1:0] ftag[$];
  int         fcnt[$];
  int errors = 0;
  int checks = 0;
  logic [TW-1:0] next_tag = 8'h10;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: queue an instruction at the fetch side
  task automatic add_instr(int n);
    ftag.push_back(next_tag);
    fcnt.push_back(n);
    next_tag = next_tag + 8'd1;
  endtask

  // one cycle: drive at negedge, judge 5 ns later, commit the model
  task automatic cycle(bit rdy, bit fl);
    int avail;
    int etake;
    int nvis;
    int pos;
    bit busy;
    item_t tent[$];
    item_t view[$];
    item_t it;
    logic [TW-1:0] ew;
    avail = (fcnt.size() < S) ? fcnt.size() : S;
    busy  = (expq.size() != 0);
    etake = 0;
    flush = fl;
    uop_ready = rdy;
    for (int s = 0; s < S; s++) begin
      grp_valid[s] = (s < avail);
      grp_tag[s]   = (s < avail) ? ftag[s] : '0;
      grp_cnt[s]   = (s < avail) ? CW'(fcnt[s]) : '0;
    end
    #5;
    if (!fl && !busy && avail > 0) begin
      etake = 1;
      if (fcnt[0] > 4) begin
        for (int i = 0; i < fcnt[0]; i++)
          tent.push_back('{tag: ftag[0], idx: CW'(i), eoi: (i == fcnt[0]-1), mseq: 1'b1});
      end else begin
        for (int i = 0; i < fcnt[0]; i++)
          tent.push_back('{tag: ftag[0], idx: CW'(i), eoi: (i == fcnt[0]-1), mseq: 1'b0});
        pos = fcnt[0];
        for (int k = 1; k < avail; k++) begin
          if (fcnt[k] == 1 && pos < S) begin
            tent.push_back('{tag: ftag[k], idx: '0, eoi: 1'b1, mseq: 1'b0});
            pos++;
            etake++;
          end else break;
        end
      end
    end
    if (!fl) begin
      if (busy) begin
        for (int i = 0; i < S && i < expq.size(); i++) view.push_back(expq[i]);
      end else begin
        foreach (tent[i]) if (!tent[i].mseq) view.push_back(tent[i]);
      end
    end
    nvis = view.size();
    // R10: contiguous valid slots, count as modelled (R3 fill)
    check(uop_valid == S'((1 << nvis) - 1), "R10", "valid slots", int'(uop_valid), (1 << nvis) - 1);
    for (int s = 0; s < nvis; s++) begin
      it = view[s];
      ew = it.mseq ? (it.tag + 8'(3 * int'(it.idx))) : (it.tag ^ {3'b000, it.idx});
      check(uop_tag[s] == it.tag && uop_idx[s] == it.idx,
            it.mseq ? "R5" : "R2", "slot tag/idx", int'({uop_tag[s], uop_idx[s]}), int'({it.tag, it.idx}));
      check(uop_eoi[s] == it.eoi && uop_mseq[s] == it.mseq,
            it.mseq ? "R5" : "R3", "slot eoi/mseq", int'({uop_eoi[s], uop_mseq[s]}), int'({it.eoi, it.mseq}));
      check(uop_word[s] == ew, "R9", "slot word", int'(uop_word[s]), int'(ew));
    end
    if (fl)
      check(grp_take == 0, "R8", "take in flush", int'(grp_take), 0);
    else if (!rdy)
      check(grp_take == 0, "R7", "take while stalled", int'(grp_take), 0);
    else
      check(int'(grp_take) == etake, "R4", "take count", int'(grp_take), etake);
    check(grp_ready == (!busy && !fl && rdy), fl ? "R8" : "R6", "grp_ready",
          int'(grp_ready), int'(!busy && !fl && rdy));
    if (fl) begin
      expq.delete();
    end else if (rdy) begin
      foreach (tent[i]) expq.push_back(tent[i]);
      for (int i = 0; i < nvis; i++) void'(expq.pop_front());
      for (int i = 0; i < etake; i++) begin
        void'(ftag.pop_front());
        void'(fcnt.pop_front());
      end
    end
    @(negedge clk);
  endtask

  task automatic drain(bit toggle);
    int n = 0;
    while ((fcnt.size() != 0 || expq.size() != 0) && n < 2000) begin
      cycle(toggle ? ((n % 3) != 1) : 1'b1, 1'b0);
      n++;
    end
    check(n < 2000, "R6", "stream drained", n, 0);
  endtask

  task automatic load_stream();
    int counts[28] = '{1,1,1,1, 3,1,1,1, 4,1, 2,1,2,1, 1,3,1, 7,1,1, 8, 5,1, 2,2,1, 12,1};
    foreach (counts[i]) add_instr(counts[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R6 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    uop_ready = 1'b1;
    @(negedge clk);
    #5;
    // R1: held in reset
    check(uop_valid == '0 && grp_take == '0, "R1", "outputs in reset",
          int'({uop_valid, grp_take}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    // R1: idle after release
    check(uop_valid == '0 && grp_take == '0 && grp_ready == uop_ready, "R1", "idle after reset",
          int'({uop_valid, grp_take, grp_ready}), 1);
    @(negedge clk);

    // steady consumer
    load_stream();
    drain(1'b0);
    // intermittent consumer
    load_stream();
    drain(1'b1);

    // flush during a running sequence (R8)
    add_instr(20);
    add_instr(1);
    add_instr(1);
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b1);
    drain(1'b0);

    // flush with a fresh group waiting (R8)
    add_instr(3);
    add_instr(1);
    cycle(1'b1, 1'b1);
    drain(1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule